// File: doc/BRIEF.md
# Timer-Shared GPIO Port Controller

This block runs a small general-purpose I/O port whose pins are also used by a timer. Software sets each pin's mode and output value through a synchronous register port. A timer output-compare channel that is enabled takes over its pin. While it is enabled, the pin drives and its level comes from the timer's compare level input. The stored direction bit does not change during this takeover. When the channel is released, the direction bit controls the pin again.

Every pad input goes through a synchronizer with two flops, clocked by the bus clock. The synchronized levels feed the timer's input-capture logic on every pin, whether the pin is driving or not. Software can read them in two ways. One is a merged data view: a pin acting as a software output returns its latch bit, and every other pin returns its synchronized level. The other is a raw pin-level view. Because of the synchronizer, a change at a pad appears in these reads two bus cycles later.

Top module: `tmrgpio_port`

## Requirements
- R1: After reset the direction register and the output latch hold 0, every pad_oe bit is 0 and every pad_out bit is 0.
- R2: A write to address 1 loads the direction register on the next clock edge. A 1 bit makes its pin drive (pad_oe=1) when its compare channel is off. A 0 bit leaves the pin as an input. Reading address 1 returns the stored bits at any time.
- R3: A write to address 0 loads the output latch on the next clock edge. For pins whose compare channel is off, pad_out equals the latch bit.
- R4: While oc_en[i] is 1, pad_oe[i] is 1 and pad_out[i] equals oc_lvl[i], whatever the direction bit and latch bit are.
- R5: The compare override never alters the direction register. Reads of address 1 are the same with and without it, and pad_oe[i] follows the direction bit again in the same cycle that oc_en[i] drops.
- R6: cap_level equals pad_in as sampled two clock edges earlier. This holds on every pin in every mode.
- R7: Reading address 0 returns, per bit, the latch bit when the pin is a software output (direction 1 and oc_en 0). Otherwise it returns the synchronized pin level.
- R8: Reading address 2 returns the synchronized pin levels, the same value as cap_level.
- R9: A write to address 3, or any cycle with bus_we low, changes neither register. Reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, applied at the next clock edge |
| bus_addr | input | 2 | Register select: 0 latch/data view, 1 direction, 2 pin levels, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| oc_en | input | 8 | Per-pin timer output-compare enable |
| oc_lvl | input | 8 | Per-pin timer compare output level |
| cap_level | output | 8 | Synchronized pin levels to the timer input capture |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
A corrupted direction bit shows up at once in two places: pad_oe for any pin whose compare channel is off, and the direction read-back. A corrupted latch bit shows up in pad_out and in the data view in the same cycle. A synchronizer with the wrong depth or a dropped stage makes cap_level and both pin read views change one cycle early or late after a pad edge, so the bench samples exactly one and two edges after each change. If the override wrongly wrote the direction register, the change would survive the release of oc_en. The bench therefore re-reads direction and pad_oe after each release.

// File: rtl/tmrgpio_pkg.sv
package tmrgpio_pkg;
    localparam int unsigned ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_LATCH = 2'd0;
    localparam logic [ADDR_W-1:0] A_DIR   = 2'd1;
    localparam logic [ADDR_W-1:0] A_PINS  = 2'd2;
endpackage

// File: rtl/tmrgpio_sync.sv
module tmrgpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d    = sh_q;
        sh_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            sh_d[k] = sh_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/tmrgpio_regs.sv
module tmrgpio_regs
    import tmrgpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  dir,
    output logic [WIDTH-1:0]  latch
);
    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] latch;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (addr)
                A_DIR:   st_d.dir   = wdata;
                A_LATCH: st_d.latch = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir   = st_q.dir;
    assign latch = st_q.latch;

    // R1
    rst_clear_chk: assert property (@(posedge clk) $rose(rst_n) |-> (st_q == '0));
    // R5
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == A_DIR) |=> $stable(st_q.dir));
    // R3
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_LATCH) |=> (st_q.latch == $past(wdata)));
    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == A_LATCH) |=> $stable(st_q.latch));
endmodule

// File: rtl/tmrgpio_pinmux.sv
module tmrgpio_pinmux #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] latch,
    input  logic [WIDTH-1:0] oc_en,
    input  logic [WIDTH-1:0] oc_lvl,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] view
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic sw_out;
        assign sw_out     = dir[i] & ~oc_en[i];
        assign pad_oe[i]  = oc_en[i] | dir[i];
        assign pad_out[i] = oc_en[i] ? oc_lvl[i] : latch[i];
        assign view[i]    = sw_out ? latch[i] : pin_sync[i];
    end
endmodule

// File: rtl/tmrgpio_port.sv
module tmrgpio_port
    import tmrgpio_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  oc_en,
    input  logic [WIDTH-1:0]  oc_lvl,
    output logic [WIDTH-1:0]  cap_level,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);
    logic [WIDTH-1:0] dir, latch, pin_sync, view;

    tmrgpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .dir(dir), .latch(latch)
    );

    tmrgpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync)
    );

    tmrgpio_pinmux #(.WIDTH(WIDTH)) u_mux (
        .dir(dir), .latch(latch), .oc_en(oc_en), .oc_lvl(oc_lvl),
        .pin_sync(pin_sync), .pad_oe(pad_oe), .pad_out(pad_out), .view(view)
    );

    assign cap_level = pin_sync;

    always_comb begin
        case (bus_addr)
            A_LATCH: bus_rdata = view;
            A_DIR:   bus_rdata = dir;
            A_PINS:  bus_rdata = pin_sync;
            default: bus_rdata = '0;
        endcase
    end

    // R4
    oc_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & oc_en) == oc_en) && (((pad_out ^ oc_lvl) & oc_en) == '0));

    // R5
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~oc_en) == (dir & ~oc_en)));

    if (SYNC_STAGES == 2) begin : g_lat_chk
        logic [1:0] warm_d, warm_q;
        always_comb warm_d = (warm_q == 2'd2) ? warm_q : warm_q + 2'd1;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) warm_q <= '0;
            else        warm_q <= warm_d;
        end
        // R6
        cap_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q == 2'd2) |-> (cap_level == $past(pad_in, 2)));
    end
endmodule

// File: tb/sim_tmrgpio_port.sv
`timescale 1ns/1ps
module sim_tmrgpio_port;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       bus_we = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, oc_en = 0, oc_lvl = 0, pad_in = 0;
    logic [7:0] bus_rdata, cap_level, pad_out, pad_oe;
    int errors = 0, checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tmrgpio_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .oc_en(oc_en),
        .oc_lvl(oc_lvl), .cap_level(cap_level), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        bus_we = 1; bus_addr = a; bus_wdata = v;
        @(posedge clk); @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a; #0.5; v = bus_rdata;
    endtask

    task automatic settle_pins(input logic [7:0] p);
        pad_in = p;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        rd(2'd1, r); chk("R1 dir", r, 8'h00);
        rst_n = 1;
        @(negedge clk);
        chk("R1 pad_oe after release", pad_oe, 8'h00);
        rd(2'd1, r); chk("R1 dir after release", r, 8'h00);

        // R2 direction sweep
        for (int v = 0; v < 256; v++) begin
            wr(2'd1, v[7:0]);
            rd(2'd1, r); chk("R2 dir readback", r, v[7:0]);
            chk("R2 pad_oe", pad_oe, v[7:0]);
        end

        // R3 latch sweep
        for (int v = 0; v < 256; v++) begin
            wr(2'd0, v[7:0]);
            chk("R3 pad_out", pad_out, v[7:0]);
        end

        // R4 / R5 override sweep
        wr(2'd1, 8'h5A);
        wr(2'd0, 8'hC3);
        for (int o = 0; o < 256; o++) begin
            oc_en  = o[7:0];
            oc_lvl = ~o[7:0] ^ 8'h33;
            @(negedge clk);
            chk("R4 pad_oe forced", pad_oe, 8'h5A | o[7:0]);
            chk("R4 pad_out mux", pad_out, (o[7:0] & oc_lvl) | (~o[7:0] & 8'hC3));
            rd(2'd1, r); chk("R5 dir kept during override", r, 8'h5A);
            oc_en = 0;
            @(negedge clk);
            chk("R5 pad_oe restored", pad_oe, 8'h5A);
            rd(2'd1, r); chk("R5 dir kept after release", r, 8'h5A);
        end

        // R6 / R8 synchronizer latency, in several modes
        for (int k = 0; k < 24; k++) begin
            logic [7:0] prev, nxt;
            wr(2'd1, k[7:0] * 8'd37);
            oc_en = k[7:0] * 8'd11;
            prev = pad_in;
            nxt = (k[7:0] * 8'd73) ^ 8'hA5;
            if (nxt == prev) nxt = ~prev;
            pad_in = nxt;
            @(negedge clk);
            chk("R6 one edge old value", cap_level, prev);
            rd(2'd2, r); chk("R8 pin view one edge", r, prev);
            @(negedge clk);
            chk("R6 two edges new value", cap_level, nxt);
            rd(2'd2, r); chk("R8 pin view two edges", r, nxt);
        end
        oc_en = 0;

        // R7 data view sweep
        for (int d = 0; d < 256; d++) begin
            logic [7:0] o, x, p, sw;
            o = d[7:0] * 8'd29 + 8'd7;
            x = d[7:0] ^ 8'h96;
            p = d[7:0] * 8'd53;
            wr(2'd1, d[7:0]);
            wr(2'd0, x);
            oc_en = o;
            settle_pins(p);
            sw = d[7:0] & ~o;
            rd(2'd0, r); chk("R7 data view", r, (sw & x) | (~sw & p));
        end
        oc_en = 0;

        // R9 unmapped address and idle bus
        wr(2'd1, 8'h3C);
        wr(2'd0, 8'hE1);
        wr(2'd3, 8'hFF);
        rd(2'd1, r); chk("R9 dir after addr3 write", r, 8'h3C);
        chk("R9 latch after addr3 write", pad_out, 8'hE1);
        rd(2'd3, r); chk("R9 addr3 reads zero", r, 8'h00);
        bus_addr = 2'd1; bus_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rd(2'd1, r); chk("R9 dir with we low", r, 8'h3C);
        chk("R9 latch with we low", pad_out, 8'hE1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule